// File: doc/BRIEF.md
# PMIC I2C Bypass Write Engine

This block is a small, dedicated I2C master that performs one single-byte register write on a power-management device per command. Software writes a packed command word holding a 7-bit device address, an 8-bit register address, an 8-bit data value and a valid flag. Setting the flag launches the transfer. The engine clears the flag itself once the bus has been released, so software learns that the write has finished by polling that bit.

The SCL waveform is timed in system-clock cycles. A clock register holds a high count and a low count, and the engine adds fixed offsets of 5 and 7 cycles to them. The bus is meant to run at up to 400 kHz with roughly 40% high and 60% low. The pins are open-drain: the block only ever pulls a line low. It reads SDA back to sample the acknowledge. This SDA path can optionally pass through a synchronizer and a majority filter.

A mode register keeps a master code, a repeated-start enable and the filter enable. The high-speed enable in that register always reads as off. Reads, arbitration, clock stretching and high-speed signalling are not part of this block.

Top module: `pmic_bypass_writer`

## Requirements
- R1: Register select 0 is the command word: device address in bits 6:0, register address in bits 15:8, data in bits 23:16, valid in bit 24, error in bit 25 (read only). All other bits read 0. A write with bit 24 clear stores the fields and starts nothing.
- R2: A command write with bit 24 set starts one transfer, and bit 24 reads 1 on the next read. Bit 24 returns to 0 only after the STOP condition and bus release are complete.
- R3: While bit 24 is set, writes to select 0 change nothing. The fields read back and the bytes sent on the bus are those of the accepted command.
- R4: Each transfer is a START, then the bytes {address,0}, register and data, each sent MSB first and followed by a ninth, acknowledge clock with SDA released, and then a STOP.
- R5: Register select 1 stores 32 bits and reads them back. Bits 7:0 (H) and 15:8 (L) set each SCL high time to H+5 cycles and each low time to L+7 cycles. The START hold before the first SCL fall is H+5 cycles.
- R6: Within a frame, the engine changes SDA only while SCL is low. The exceptions are the START (SDA falls with SCL high) and the STOP (SDA rises with SCL high).
- R7: If SDA reads high at the end of any acknowledge clock, the engine sends no further bytes, issues a STOP, sets error bit 25 and clears bit 24.
- R8: The error bit stays set until the next transfer is accepted. A command write with bit 24 clear does not clear it.
- R9: Register select 2 keeps bits 1:0 (master code), 4 (repeated-start enable) and 6 (filter enable). Bit 3 (high-speed enable) and all other bits always read 0, so writing all ones reads back 0x53.
- R10: With bit 6 of select 2 set, the acknowledge is taken through a 2-flop synchronizer and a 3-sample majority vote. An ACK on which SDA is released for one cycle in every three is therefore still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 command, 1 clock, 2 mode |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for cfg_sel of the previous cycle |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level sensed on the SDA line |

## Verification
A stuck or mis-stepped sequencer state is visible on the pins within one SCL half-period. It shows up as a high or low time that differs from H+5 or L+7, or as an SDA edge while SCL is high. A wrong bit or byte counter shows up at the first acknowledge clock, where the bytes the bench's device model collects no longer match the command fields. Errors in the lock or the sticky flag surface on the next read of select 0, one cycle after the read is issued. The sweep covers several clock counts, a NACK at each byte position, and filter on and off, so each of these faults is seen within a few transfers.

// File: rtl/pmic_wr_pkg.sv
package pmic_wr_pkg;
  localparam int SA_W      = 7;
  localparam int BYTE_W    = 8;
  localparam int NBYTES    = 3;
  localparam int WORD_W    = 32;
  localparam int VALID_BIT = 24;
  localparam int ERR_BIT   = 25;
  localparam int RA_POS    = 8;
  localparam int DAT_POS   = 16;
  localparam int LO_POS    = 8;
  localparam int HI_ADD    = 5;
  localparam int LO_ADD    = 7;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_CLK  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LOW,
    ST_STOP_HIGH,
    ST_STOP_REL
  } eng_st_t;
endpackage

// File: rtl/pmic_wr_regs.sv
module pmic_wr_regs
  import pmic_wr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           sel,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  input  logic                 done_i,
  input  logic                 nack_i,
  output logic                 start_o,
  output logic [SA_W-1:0]      sa_o,
  output logic [BYTE_W-1:0]    ra_o,
  output logic [BYTE_W-1:0]    dat_o,
  output logic [CNT_W-1:0]     hi_o,
  output logic [CNT_W-1:0]     lo_o,
  output logic                 filt_en_o
);
  logic [SA_W-1:0]   sa_q;
  logic [BYTE_W-1:0] ra_q, dat_q;
  logic              valid_q, err_q, start_q;
  logic [WORD_W-1:0] clk_q;
  logic [1:0]        mcode_q;
  logic              sr_q, filt_q;
  logic              accept;

  assign accept = wr_en && (sel == SEL_CMD) && !valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa_q    <= '0;
      ra_q    <= '0;
      dat_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      clk_q   <= '0;
      mcode_q <= '0;
      sr_q    <= 1'b0;
      filt_q  <= 1'b0;
    end else begin
      start_q <= accept && wdata[VALID_BIT];
      if (accept) begin
        sa_q    <= wdata[SA_W-1:0];
        ra_q    <= wdata[RA_POS +: BYTE_W];
        dat_q   <= wdata[DAT_POS +: BYTE_W];
        valid_q <= wdata[VALID_BIT];
        if (wdata[VALID_BIT]) err_q <= 1'b0;
      end else if (done_i) begin
        valid_q <= 1'b0;
        if (nack_i) err_q <= 1'b1;
      end
      if (wr_en && sel == SEL_CLK) clk_q <= wdata;
      if (wr_en && sel == SEL_MODE) begin
        mcode_q <= wdata[1:0];
        sr_q    <= wdata[4];
        filt_q  <= wdata[6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_CMD:  rdata <= {6'd0, err_q, valid_q, dat_q, ra_q, 1'b0, sa_q};
        SEL_CLK:  rdata <= clk_q;
        SEL_MODE: rdata <= {25'd0, filt_q, 1'b0, sr_q, 2'b00, mcode_q};
        default:  rdata <= '0;
      endcase
    end
  end

  assign start_o   = start_q;
  assign sa_o      = sa_q;
  assign ra_o      = ra_q;
  assign dat_o     = dat_q;
  assign hi_o      = clk_q[CNT_W-1:0];
  assign lo_o      = clk_q[LO_POS +: CNT_W];
  assign filt_en_o = filt_q;

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CMD && valid_q) |=> ($stable(sa_q) && $stable(ra_q) && $stable(dat_q))); // R3
  AST_VALID_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_q) |-> $past(done_i)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(accept && wdata[VALID_BIT])) |=> err_q); // R8
  AST_HS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_MODE) |=> !rdata[3]); // R9
endmodule

// File: rtl/pmic_wr_sda_filt.sv
module pmic_wr_sda_filt #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sda_raw,
  output logic sda_o
);
  logic [SYNC_N-1:0] sync_q;
  logic [1:0]        hist_q;
  logic              maj_q;
  logic              newest;

  assign newest = sync_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      maj_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], sda_raw};
      hist_q <= {hist_q[0], newest};
      maj_q  <= (newest & hist_q[0]) | (newest & hist_q[1]) | (hist_q[0] & hist_q[1]);
    end
  end

  assign sda_o = en ? maj_q : sda_raw;
endmodule

// File: rtl/pmic_wr_seq.sv
module pmic_wr_seq
  import pmic_wr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [SA_W-1:0]    sa_i,
  input  logic [BYTE_W-1:0]  ra_i,
  input  logic [BYTE_W-1:0]  dat_i,
  input  logic [CNT_W-1:0]   hi_i,
  input  logic [CNT_W-1:0]   lo_i,
  input  logic               sda_s,
  output logic               scl_pull,
  output logic               sda_pull,
  output logic               done_o,
  output logic               nack_o
);
  localparam int CW      = CNT_W + 1;
  localparam int FRAME_W = NBYTES * (BYTE_W + 1);
  localparam int BN_W    = $clog2(BYTE_W + 1);
  localparam int BY_W    = $clog2(NBYTES);

  eng_st_t              st;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        hi_lim, lo_lim;
  logic [FRAME_W-1:0]   frame_q;
  logic [BN_W-1:0]      bitn;
  logic [BY_W-1:0]      byten;
  logic                 fail_q;
  logic                 hi_end, lo_end;

  assign hi_lim = {1'b0, hi_i} + CW'(HI_ADD);
  assign lo_lim = {1'b0, lo_i} + CW'(LO_ADD);
  assign hi_end = (cnt == hi_lim - 1'b1);
  assign lo_end = (cnt == lo_lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      frame_q  <= '0;
      bitn     <= '0;
      byten    <= '0;
      fail_q   <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      done_o   <= 1'b0;
      nack_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      nack_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            frame_q  <= {sa_i, 1'b0, 1'b1, ra_i, 1'b1, dat_i, 1'b1};
            bitn     <= '0;
            byten    <= '0;
            fail_q   <= 1'b0;
            cnt      <= '0;
            sda_pull <= 1'b1;
            st       <= ST_START;
          end
        end
        ST_START: begin
          if (hi_end) begin
            cnt      <= '0;
            scl_pull <= 1'b1;
            st       <= ST_LOW;
          end else cnt <= cnt + 1'b1;
        end
        ST_LOW: begin
          if (cnt == '0) sda_pull <= !frame_q[FRAME_W-1];
          if (lo_end) begin
            cnt      <= '0;
            scl_pull <= 1'b0;
            st       <= ST_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        ST_HIGH: begin
          if (hi_end) begin
            cnt      <= '0;
            scl_pull <= 1'b1;
            frame_q  <= frame_q << 1;
            if (bitn == BN_W'(BYTE_W)) begin
              bitn <= '0;
              if (sda_s) begin
                fail_q <= 1'b1;
                st     <= ST_STOP_LOW;
              end else if (byten == BY_W'(NBYTES - 1)) begin
                st <= ST_STOP_LOW;
              end else begin
                byten <= byten + 1'b1;
                st    <= ST_LOW;
              end
            end else begin
              bitn <= bitn + 1'b1;
              st   <= ST_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP_LOW: begin
          if (cnt == '0) sda_pull <= 1'b1;
          if (lo_end) begin
            cnt      <= '0;
            scl_pull <= 1'b0;
            st       <= ST_STOP_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP_HIGH: begin
          if (hi_end) begin
            cnt      <= '0;
            sda_pull <= 1'b0;
            st       <= ST_STOP_REL;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP_REL: begin
          if (hi_end) begin
            cnt    <= '0;
            done_o <= 1'b1;
            nack_o <= fail_q;
            st     <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ((sda_pull != $past(sda_pull)) && st != ST_START && st != ST_STOP_REL)
      |-> (scl_pull && $past(scl_pull))); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOW || st == ST_STOP_LOW) |-> (cnt < lo_lim)); // R5
  AST_NACK_TO_STOP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HIGH && hi_end && bitn == BN_W'(BYTE_W) && sda_s) |=> (st == ST_STOP_LOW)); // R7
endmodule

// File: rtl/pmic_bypass_writer.sv
module pmic_bypass_writer
  import pmic_wr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              sda_in
);
  logic              start_w, done_w, nack_w, filt_en_w, sda_s_w;
  logic [SA_W-1:0]   sa_w;
  logic [BYTE_W-1:0] ra_w, dat_w;
  logic [CNT_W-1:0]  hi_w, lo_w;

  pmic_wr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .done_i(done_w), .nack_i(nack_w), .start_o(start_w),
    .sa_o(sa_w), .ra_o(ra_w), .dat_o(dat_w), .hi_o(hi_w), .lo_o(lo_w),
    .filt_en_o(filt_en_w)
  );

  pmic_wr_sda_filt #(.SYNC_N(SYNC_N)) u_filt (
    .clk(clk), .rst(rst), .en(filt_en_w), .sda_raw(sda_in), .sda_o(sda_s_w)
  );

  pmic_wr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_w), .sa_i(sa_w), .ra_i(ra_w),
    .dat_i(dat_w), .hi_i(hi_w), .lo_i(lo_w), .sda_s(sda_s_w),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .done_o(done_w), .nack_o(nack_w)
  );
endmodule

// File: tb/sim_pmic_bypass_writer.sv
`timescale 1ns/1ps
module sim_pmic_bypass_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        scl_pull, sda_pull, sda_in;
  logic        dev_pull = 1'b0;

  int total = 0, bad = 0;
  int stops = 0, tbad = 0, r6bad = 0, rxcnt = 0;
  logic [7:0] rx [0:3];
  int h_exp = 5, l_exp = 7, nack_at = 3;
  bit glitch = 0;

  always #4 clk = ~clk;
  assign sda_in = !(sda_pull | dev_pull);

  pmic_bypass_writer u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    cfg_sel = s;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  // device model: decodes the pins, checks timing and SDA edges, drives ACK
  initial begin
    bit pscl = 1, psda = 1, in_fr = 0, first = 0, ackon = 0;
    int bitc = 0, since = 0, hcnt = 0;
    logic [7:0] sh = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        bit scl, dsda;
        scl = !scl_pull;
        dsda = !sda_pull;
        if (!in_fr && pscl && scl && psda && !dsda) begin
          in_fr = 1; bitc = 0; sh = '0; since = 0; first = 1; rxcnt = 0;
        end else if (in_fr && pscl && scl && !psda && dsda) begin
          in_fr = 0; stops++; ackon = 0; dev_pull = 0;
        end else if (in_fr) begin
          if (pscl && scl && psda && !dsda) r6bad++;
          if (!pscl && scl) begin
            if (since != l_exp) tbad++;
            if (bitc < 8) sh = {sh[6:0], dsda};
            bitc++; since = 0; hcnt = 0;
          end else if (pscl && !scl) begin
            if (since != h_exp) tbad++;
            first = 0;
            if (bitc == 8) begin
              rx[rxcnt] = sh; ackon = (nack_at != rxcnt); rxcnt++;
            end else if (bitc == 9) begin
              ackon = 0; bitc = 0;
            end
            since = 0;
          end
          if (ackon) begin
            if (scl && glitch) begin
              dev_pull = (hcnt % 3) != 0;
              hcnt++;
            end else dev_pull = 1;
          end else dev_pull = 0;
        end
        since++;
        pscl = scl; psda = dsda;
      end
    end
  end

  task automatic xfer(input int h, input int l, input logic [6:0] sa, input logic [7:0] ra,
                      input logic [7:0] dt, input int nk, input bit filt, input bit overwrite);
    logic [31:0] v, cmd;
    int s0, t0, r0, nexp;
    logic [7:0] exp_b [0:2];
    wr(2'd1, {16'hA5C3, 8'(l), 8'(h)});
    rd(2'd1, v);
    chk(v == {16'hA5C3, 8'(l), 8'(h)}, "R5 clock readback", v, {16'hA5C3, 8'(l), 8'(h)});
    wr(2'd2, filt ? 32'h40 : 32'h0);
    h_exp = h + 5; l_exp = l + 7; nack_at = nk; glitch = filt;
    s0 = stops; t0 = tbad; r0 = r6bad;
    cmd = {7'd0, 1'b1, dt, ra, 1'b0, sa};
    wr(2'd0, cmd);
    rd(2'd0, v);
    chk(v[24] == 1'b1, "R2 valid set after start", v, cmd);
    if (overwrite) wr(2'd0, {7'd0, 1'b1, ~dt, ~ra, 1'b0, ~sa});
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, v);
      if (!v[24]) break;
    end
    chk(v[24] == 1'b0, "R2 valid self-clears", v, 32'h0);
    chk(v[23:0] == cmd[23:0], "R1 R3 command fields kept", v, cmd);
    chk(v[25] == (nk < 3), "R7 R10 error flag", {31'd0, v[25]}, {31'd0, nk < 3});
    chk(stops == s0 + 1, "R4 R7 one STOP per transfer", stops, s0 + 1);
    nexp = (nk < 3) ? nk + 1 : 3;
    exp_b[0] = {sa, 1'b0}; exp_b[1] = ra; exp_b[2] = dt;
    chk(rxcnt == nexp, "R4 R7 bytes on bus", rxcnt, nexp);
    for (int b = 0; b < 3; b++)
      if (b < nexp) chk(rx[b] == exp_b[b], "R4 byte value", {24'd0, rx[b]}, {24'd0, exp_b[b]});
    chk(tbad == t0, "R5 SCL high/low/start timing", tbad - t0, 0);
    chk(r6bad == r0, "R6 SDA edge with SCL high", r6bad - r0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hs [4] = '{0, 3, 12, 25};
    int ls [4] = '{0, 1, 7, 40};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R6 idle bus after reset", {scl_pull, sda_pull}, 0);
    rd(2'd0, v);
    chk(v == 32'h0, "R1 reset command word", v, 0);
    wr(2'd0, 32'h00_C3_5A_2B);
    rd(2'd0, v);
    chk(v == 32'h00_C3_5A_2B, "R1 fields stored without valid", v, 32'h00_C3_5A_2B);
    repeat (10) @(negedge clk);
    chk(stops == 0 && scl_pull == 0 && sda_pull == 0, "R1 no transfer without valid", stops, 0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v);
    chk(v == 32'h53, "R9 mode readback, HS enable zero", v, 32'h53);
    wr(2'd2, 32'h08);
    rd(2'd2, v);
    chk(v == 32'h0, "R9 HS enable alone reads zero", v, 0);

    for (int t = 0; t < 4; t++)
      for (int n = 0; n < 4; n++)
        for (int f = 0; f < 2; f++) begin
          xfer(hs[t], ls[t], 7'(t * 37 + n * 11 + f * 5 + 1), 8'(t * 73 + n * 29 + 16),
               8'(~(t * 73 + n * 29 + 16) ^ t), n, f[0], (n == 3 && f == 1));
          if (n < 3) begin
            wr(2'd0, 32'h0000_0011);
            rd(2'd0, v);
            chk(v[25] == 1'b1 && v[24] == 1'b0, "R8 error sticky over non-start write", v, 32'h0200_0011);
          end
        end

    xfer(2, 2, 7'h7F, 8'hFF, 8'h00, 3, 1'b0, 1'b0);
    xfer(2, 2, 7'h00, 8'h00, 8'hFF, 3, 1'b1, 1'b0);
    xfer(0, 0, 7'h55, 8'hAA, 8'h5A, 3, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule